// File: doc/BRIEF.md
# Command Post Queue Host Interface

This block sits on the controller side of a storage adapter. It gives the host a small set of 32-bit registers for passing commands. The host posts a command descriptor address by writing one register, and the address goes into an inbound FIFO. The controller's command engine drains that FIFO through a valid/ready port.

Completions go the other way. The engine pushes each finished tag, with an error flag, into an outbound FIFO through a second valid/ready port. The host collects a completion by reading one register, and that read also removes the entry. When the outbound FIFO holds no entries, the read returns an all-ones sentinel.

An interrupt line is raised while completions wait. It can be gated by a mask register that the host can read back, and it can be acknowledged through a doorbell clear register. A separate inbound doorbell bit gives the engine a one-cycle pulse saying that the configuration table has changed.

Top module: `cpq_host_if`

## Requirements
- R1: Each host write to offset 0x40 appends the 32-bit write data to a 16-entry inbound FIFO. The controller receives the entries in posting order on `ib_data_o`, and an entry is removed when `ib_valid_o` and `ib_ready_i` are both high at a clock edge.
- R2: A write to 0x40 while the inbound FIFO holds 16 entries is dropped and sets a sticky overflow flag. The flag stays set until the host writes 1 to bit 1 of offset 0x9C.
- R3: A host read of offset 0x44 returns the oldest outbound entry, and that entry is removed at the clock edge that ends the read. A read of 0x44 while the outbound FIFO is empty returns 0xFFFFFFFF and changes nothing.
- R4: A completion accepted with `cq_err_i` high is stored as `cq_tag_i` with bit 1 forced to 1. With `cq_err_i` low, the tag is stored unchanged.
- R5: `cq_ready_o` is low exactly while the outbound FIFO holds 16 entries. A completion offered in that state is held off and is not stored.
- R6: Bit 3 of the status register at 0x30 is 1 while the outbound FIFO is non-empty and no acknowledge is pending. Writing a value with bit 0 set to offset 0xA0 acknowledges and clears that bit. The next accepted completion raises the bit again. A write to 0xA0 with bit 0 clear has no effect.
- R7: The mask register at 0x34 resets to 0xFFFFFFFF and reads back the last value written. `irq_o` is high when some status bit is 1 and the matching mask bit is 0.
- R8: A write to offset 0x20 with bit 0 set produces `cfg_upd_o` high for exactly the one cycle after the write. A write to 0x20 with bit 0 clear produces no pulse.
- R9: A read of offset 0x9C returns the following fields: bit 0 is outbound FIFO non-empty, bit 1 is the overflow flag, bits 12:8 are the inbound entry count, bits 20:16 are the outbound entry count, and all other bits are 0.
- R10: A read of any offset other than 0x30, 0x34, 0x44 and 0x9C returns 0. A write to any offset other than 0x20, 0x34, 0x40, 0x9C and 0xA0 changes no state.
- R11: A host read-pop of a non-empty outbound FIFO and an accepted completion push in the same cycle both take effect, and the outbound count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_rd_i | input | 1 | Host register read strobe |
| reg_addr_i | input | 8 | Host register byte offset |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data, valid in the cycle that `reg_rd_i` is high |
| irq_o | output | 1 | Interrupt to the host |
| cfg_upd_o | output | 1 | One-cycle pulse signalling a configuration table update |
| ib_valid_o | output | 1 | Inbound entry available to the controller |
| ib_ready_i | input | 1 | Controller takes the inbound entry |
| ib_data_o | output | 32 | Oldest posted command address |
| cq_valid_i | input | 1 | Completion offered by the controller |
| cq_ready_o | output | 1 | Outbound FIFO can accept a completion |
| cq_tag_i | input | 32 | Completion tag |
| cq_err_i | input | 1 | Completion finished with an error |

## Verification
The bench fills the inbound FIFO with the consumer stalled and posts one extra address. A design that wrapped or overwrote an entry would later deliver a wrong or duplicated address, and a design that lost the sticky flag would report no overflow.

It drives the outbound FIFO to full and checks that completions are held off there, not silently dropped. It then pops and pushes in the same cycle. A design that honoured only one side would show a count off by one and a missing tag at drain time.

The interrupt is exercised through masking, acknowledge, and re-arm on a new completion. A design that let an acknowledge persist across a push would leave the host without an interrupt for that completion. Empty-queue reads must return the sentinel without disturbing the count.

// File: rtl/cpq_pkg.sv
package cpq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  typedef enum logic [AW-1:0] {
    OFS_IDB = 8'h20,
    OFS_ISR = 8'h30,
    OFS_IMR = 8'h34,
    OFS_IPQ = 8'h40,
    OFS_OPQ = 8'h44,
    OFS_OSR = 8'h9C,
    OFS_ODC = 8'hA0
  } reg_ofs_e;

  localparam logic [DW-1:0] OPQ_EMPTY = '1;

  // status register field positions
  localparam int unsigned OSR_NEMPTY = 0;
  localparam int unsigned OSR_OVF    = 1;
  localparam int unsigned OSR_IBCNT  = 8;
  localparam int unsigned OSR_OBCNT  = 16;

  function automatic logic [DW-1:0] fmt_cpl(input logic [DW-1:0] tag, input logic err);
    return tag | {{(DW-2){1'b0}}, err, 1'b0};
  endfunction
endpackage

// File: rtl/cpq_fifo.sv
module cpq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  logic [W-1:0]           data_i,
  input  logic                   pop_i,
  output logic [W-1:0]           data_o,
  output logic                   full_o,
  output logic                   empty_o,
  output logic [$clog2(DEPTH):0] cnt_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH) + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rp_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end
endmodule

// File: rtl/cpq_irq_ctrl.sv
module cpq_irq_ctrl #(
  parameter int W       = 32,
  parameter int OPQ_BIT = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ob_nempty_i,
  input  logic         ob_push_i,
  input  logic         ack_i,
  input  logic         imr_we_i,
  input  logic [W-1:0] imr_wdata_i,
  output logic [W-1:0] isr_o,
  output logic [W-1:0] imr_o,
  output logic         irq_o
);
  logic         acked_q;
  logic [W-1:0] imr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acked_q <= 1'b0;
      imr_q   <= '1;
    end else begin
      // a fresh completion re-arms the source
      if (ob_push_i)  acked_q <= 1'b0;
      else if (ack_i) acked_q <= 1'b1;
      if (imr_we_i) imr_q <= imr_wdata_i;
    end
  end

  always_comb begin
    isr_o          = '0;
    isr_o[OPQ_BIT] = ob_nempty_i && !acked_q;
  end

  assign imr_o = imr_q;
  assign irq_o = |(isr_o & ~imr_q);
endmodule

// File: rtl/cpq_reg_dec.sv
module cpq_reg_dec
  import cpq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic [CW-1:0] ib_cnt_i,
  input  logic [CW-1:0] ob_cnt_i,
  input  logic          ob_empty_i,
  input  logic [DW-1:0] ob_head_i,
  input  logic          ovf_i,
  input  logic [DW-1:0] isr_i,
  input  logic [DW-1:0] imr_i,
  output logic          ib_push_o,
  output logic          ob_pop_o,
  output logic          ack_o,
  output logic          imr_we_o,
  output logic          cfg_set_o,
  output logic          ovf_clr_o,
  output logic [DW-1:0] reg_rdata_o
);
  logic [DW-1:0] osr;

  always_comb begin
    osr                     = '0;
    osr[OSR_NEMPTY]         = !ob_empty_i;
    osr[OSR_OVF]            = ovf_i;
    osr[OSR_IBCNT +: CW]    = ib_cnt_i;
    osr[OSR_OBCNT +: CW]    = ob_cnt_i;
  end

  assign ib_push_o = reg_wr_i && (reg_addr_i == OFS_IPQ);
  assign imr_we_o  = reg_wr_i && (reg_addr_i == OFS_IMR);
  assign ack_o     = reg_wr_i && (reg_addr_i == OFS_ODC) && reg_wdata_i[0];
  assign cfg_set_o = reg_wr_i && (reg_addr_i == OFS_IDB) && reg_wdata_i[0];
  assign ovf_clr_o = reg_wr_i && (reg_addr_i == OFS_OSR) && reg_wdata_i[OSR_OVF];
  assign ob_pop_o  = reg_rd_i && (reg_addr_i == OFS_OPQ);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      case (reg_addr_i)
        OFS_ISR: reg_rdata_o = isr_i;
        OFS_IMR: reg_rdata_o = imr_i;
        OFS_OPQ: reg_rdata_o = ob_empty_i ? OPQ_EMPTY : ob_head_i;
        OFS_OSR: reg_rdata_o = osr;
        default: reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cpq_host_if.sv
module cpq_host_if
  import cpq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int OPQ_BIT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o,
  output logic          cfg_upd_o,
  output logic          ib_valid_o,
  input  logic          ib_ready_i,
  output logic [DW-1:0] ib_data_o,
  input  logic          cq_valid_i,
  output logic          cq_ready_o,
  input  logic [DW-1:0] cq_tag_i,
  input  logic          cq_err_i
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          ib_push, ib_full, ib_empty;
  logic [CW-1:0] ib_cnt;
  logic          ob_pop, ob_push, ob_full, ob_empty;
  logic [CW-1:0] ob_cnt;
  logic [DW-1:0] ob_head;
  logic          ack, imr_we, cfg_set, ovf_clr, ovf_q;
  logic [DW-1:0] isr, imr_q;

  assign ob_push    = cq_valid_i && !ob_full;
  assign cq_ready_o = !ob_full;
  assign ib_valid_o = !ib_empty;

  cpq_fifo #(.W(DW), .DEPTH(DEPTH)) u_ib_fifo (
    .clk_i, .rst_ni,
    .push_i (ib_push),
    .data_i (reg_wdata_i),
    .pop_i  (ib_ready_i),
    .data_o (ib_data_o),
    .full_o (ib_full),
    .empty_o(ib_empty),
    .cnt_o  (ib_cnt)
  );

  cpq_fifo #(.W(DW), .DEPTH(DEPTH)) u_ob_fifo (
    .clk_i, .rst_ni,
    .push_i (ob_push),
    .data_i (fmt_cpl(cq_tag_i, cq_err_i)),
    .pop_i  (ob_pop),
    .data_o (ob_head),
    .full_o (ob_full),
    .empty_o(ob_empty),
    .cnt_o  (ob_cnt)
  );

  cpq_irq_ctrl #(.W(DW), .OPQ_BIT(OPQ_BIT)) u_irq (
    .clk_i, .rst_ni,
    .ob_nempty_i(!ob_empty),
    .ob_push_i  (ob_push),
    .ack_i      (ack),
    .imr_we_i   (imr_we),
    .imr_wdata_i(reg_wdata_i),
    .isr_o      (isr),
    .imr_o      (imr_q),
    .irq_o      (irq_o)
  );

  cpq_reg_dec #(.CW(CW)) u_dec (
    .reg_wr_i, .reg_rd_i, .reg_addr_i, .reg_wdata_i,
    .ib_cnt_i   (ib_cnt),
    .ob_cnt_i   (ob_cnt),
    .ob_empty_i (ob_empty),
    .ob_head_i  (ob_head),
    .ovf_i      (ovf_q),
    .isr_i      (isr),
    .imr_i      (imr_q),
    .ib_push_o  (ib_push),
    .ob_pop_o   (ob_pop),
    .ack_o      (ack),
    .imr_we_o   (imr_we),
    .cfg_set_o  (cfg_set),
    .ovf_clr_o  (ovf_clr),
    .reg_rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q     <= 1'b0;
      cfg_upd_o <= 1'b0;
    end else begin
      cfg_upd_o <= cfg_set;
      // a new drop wins over a same-cycle clear
      if (ib_push && ib_full) ovf_q <= 1'b1;
      else if (ovf_clr)       ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cpq_host_if_chk.sv
module cpq_host_if_chk
  import cpq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int OPQ_BIT = 3,
  parameter int CW      = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_wr_i,
  input logic          reg_rd_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [1:0]    wdata_lo_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic          irq_o,
  input logic          cfg_upd_o,
  input logic          cq_valid_i,
  input logic          cq_ready_o,
  input logic [CW-1:0] ib_cnt_i,
  input logic [CW-1:0] ob_cnt_i,
  input logic          ovf_i,
  input logic [DW-1:0] imr_i
);
  logic unmapped_rd;
  assign unmapped_rd = reg_rd_i && !(reg_addr_i inside {OFS_ISR, OFS_IMR, OFS_OPQ, OFS_OSR});

  AST_IB_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_cnt_i <= CW'(DEPTH)); // R1
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i && !(reg_wr_i && reg_addr_i == OFS_OSR && wdata_lo_i[1]) |=> ovf_i); // R2
  AST_EMPTY_SENTINEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i && reg_addr_i == OFS_OPQ && ob_cnt_i == '0 |-> reg_rdata_o == OPQ_EMPTY); // R3
  AST_STALL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ob_cnt_i == CW'(DEPTH) |-> !cq_ready_o); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imr_i[OPQ_BIT] |-> !irq_o); // R7
  AST_CFG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_upd_o |-> $past(reg_wr_i && reg_addr_i == OFS_IDB && wdata_lo_i[0])); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_rd |-> reg_rdata_o == '0); // R10
  AST_SIMUL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i && reg_addr_i == OFS_OPQ && ob_cnt_i != '0 && cq_valid_i && cq_ready_o
    |=> $stable(ob_cnt_i)); // R11
endmodule

bind cpq_host_if cpq_host_if_chk #(.DEPTH(DEPTH), .OPQ_BIT(OPQ_BIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_rd_i   (reg_rd_i),
  .reg_addr_i (reg_addr_i),
  .wdata_lo_i (reg_wdata_i[1:0]),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .cfg_upd_o  (cfg_upd_o),
  .cq_valid_i (cq_valid_i),
  .cq_ready_o (cq_ready_o),
  .ib_cnt_i   (ib_cnt),
  .ob_cnt_i   (ob_cnt),
  .ovf_i      (ovf_q),
  .imr_i      (imr_q)
);

// File: tb/cpq_host_if_test.sv
module cpq_host_if_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, cfg_upd, ib_valid, ib_ready = 1'b0, cq_valid = 1'b0, cq_ready, cq_err = 1'b0;
  logic [31:0] ib_data, cq_tag = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] ib_q[$];
  logic [31:0] ob_q[$];

  always #10 clk = ~clk;

  cpq_host_if uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .cfg_upd_o(cfg_upd),
    .ib_valid_o(ib_valid), .ib_ready_i(ib_ready), .ib_data_o(ib_data),
    .cq_valid_i(cq_valid), .cq_ready_o(cq_ready), .cq_tag_i(cq_tag), .cq_err_i(cq_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // inbound monitor: compare each controller pop with the scoreboard
  always @(negedge clk) begin
    if (rst_n && ib_valid && ib_ready) begin
      if (ib_q.size() == 0) chk("R1 unexpected entry", ib_data, 32'h0);
      else chk("R1 inbound order", ib_data, ib_q.pop_front());
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #5;
    wr = 1'b1; addr = a; wdata = d;
    if (a == 8'h40 && ib_q.size() < 16) ib_q.push_back(d);
    @(posedge clk); #5;
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #5;
    rd = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    @(posedge clk); #5;
    rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic opq_read(input string req);
    logic [31:0] v;
    bus_rd(8'h44, v);
    chk(req, v, (ob_q.size() != 0) ? ob_q.pop_front() : 32'hFFFF_FFFF);
  endtask

  task automatic cq_push(input logic [31:0] tag, input logic err);
    bit ok = 0;
    @(posedge clk); #5;
    cq_valid = 1'b1; cq_tag = tag; cq_err = err;
    for (int i = 0; i < 50 && !ok; i++) begin
      @(negedge clk);
      if (cq_ready) ok = 1;
      @(posedge clk); #5;
    end
    cq_valid = 1'b0;
    if (ok) ob_q.push_back(tag | {30'b0, err, 1'b0});
    else chk("R5 push never accepted", 32'h0, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset irq", {31'b0, irq}, 32'h0);
    chk("R1 reset ib_valid", {31'b0, ib_valid}, 32'h0);
    chk("R5 reset cq_ready", {31'b0, cq_ready}, 32'h1);
    chk("R8 reset cfg_upd", {31'b0, cfg_upd}, 32'h0);
    rd_chk("R7 mask reset value", 8'h34, 32'hFFFF_FFFF);
    rd_chk("R9 status reset", 8'h9C, 32'h0);
    opq_read("R3 empty sentinel");

    // R1: ordered delivery with consumer ready
    ib_ready = 1'b1;
    bus_wr(8'h40, 32'h0000_1000);
    bus_wr(8'h40, 32'h0000_2004);
    bus_wr(8'h40, 32'hDEAD_BEE0);
    repeat (4) @(posedge clk);
    chk("R1 all delivered", ib_q.size(), 0);

    // R2: overflow with consumer stalled
    @(posedge clk); #5 ib_ready = 1'b0;
    for (int i = 1; i <= 17; i++) bus_wr(8'h40, i << 4);
    @(negedge clk);
    chk("R1 valid while stalled", {31'b0, ib_valid}, 32'h1);
    rd_chk("R2 R9 overflow and count", 8'h9C, 32'h0000_1002);
    bus_wr(8'h9C, 32'h0000_0001);
    rd_chk("R2 clear needs bit1", 8'h9C, 32'h0000_1002);
    bus_wr(8'h9C, 32'h0000_0002);
    rd_chk("R2 overflow cleared", 8'h9C, 32'h0000_1000);
    @(posedge clk); #5 ib_ready = 1'b1;
    repeat (20) @(posedge clk);
    chk("R2 dropped entry absent", ib_q.size(), 0);
    rd_chk("R9 inbound drained", 8'h9C, 32'h0);
    @(posedge clk); #5 ib_ready = 1'b0;

    // R4 and R6/R7: completion format, mask, acknowledge
    cq_push(32'h0000_0100, 1'b0);
    @(negedge clk);
    chk("R7 masked irq low", {31'b0, irq}, 32'h0);
    rd_chk("R6 status pending", 8'h30, 32'h0000_0008);
    bus_wr(8'h34, 32'h0);
    @(negedge clk);
    chk("R7 unmasked irq high", {31'b0, irq}, 32'h1);
    rd_chk("R7 mask readback", 8'h34, 32'h0);
    bus_wr(8'hA0, 32'h0000_0000);
    @(negedge clk);
    chk("R6 ack needs bit0", {31'b0, irq}, 32'h1);
    bus_wr(8'hA0, 32'h0000_0001);
    @(negedge clk);
    chk("R6 ack drops irq", {31'b0, irq}, 32'h0);
    rd_chk("R6 status after ack", 8'h30, 32'h0);
    rd_chk("R9 nonempty after ack", 8'h9C, 32'h0001_0001);
    cq_push(32'hABCD_0000, 1'b1);
    @(negedge clk);
    chk("R6 rearm on push", {31'b0, irq}, 32'h1);
    opq_read("R3 oldest first");
    opq_read("R4 error flag in bit1");
    @(negedge clk);
    chk("R6 irq clears when empty", {31'b0, irq}, 32'h0);
    opq_read("R3 sentinel after drain");
    bus_wr(8'h34, 32'hFFFF_FFFF);

    // R5: fill outbound queue
    for (int i = 0; i < 16; i++) cq_push(32'h0001_0000 + (i << 4), i[0]);
    @(negedge clk);
    chk("R5 ready low when full", {31'b0, cq_ready}, 32'h0);
    rd_chk("R9 outbound full count", 8'h9C, 32'h0010_0001);
    for (int i = 0; i < 13; i++) opq_read("R3 R4 drain order");

    // R11: simultaneous pop and push with 3 entries
    @(posedge clk); #5;
    rd = 1'b1; addr = 8'h44;
    cq_valid = 1'b1; cq_tag = 32'h0777_7770; cq_err = 1'b1;
    @(negedge clk);
    chk("R11 pop data", rdata, ob_q.pop_front());
    chk("R11 push accepted", {31'b0, cq_ready}, 32'h1);
    @(posedge clk); #5;
    rd = 1'b0; cq_valid = 1'b0;
    ob_q.push_back(32'h0777_7772);
    rd_chk("R11 count unchanged", 8'h9C, 32'h0003_0001);
    for (int i = 0; i < 3; i++) opq_read("R11 tail order");
    opq_read("R3 final sentinel");

    // R8: doorbell pulse
    bus_wr(8'h20, 32'h0000_0001);
    @(negedge clk);
    chk("R8 pulse high", {31'b0, cfg_upd}, 32'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, cfg_upd}, 32'h0);
    bus_wr(8'h20, 32'h0000_0002);
    @(negedge clk);
    chk("R8 no pulse bit0 clear", {31'b0, cfg_upd}, 32'h0);

    // R10: unmapped offsets
    rd_chk("R10 unmapped read 0x50", 8'h50, 32'h0);
    rd_chk("R10 doorbell reads zero", 8'h20, 32'h0);
    bus_wr(8'h38, 32'h0);
    bus_wr(8'h48, 32'h1234_5678);
    rd_chk("R10 mask untouched", 8'h34, 32'hFFFF_FFFF);
    rd_chk("R10 queues untouched", 8'h9C, 32'h0);
    v = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule